// File: doc/BRIEF.md
# Jitter Attenuator Elastic Bit Store

The block is a one-bit-wide elastic store that sits between an irregular write strobe, which carries a bit stream with short-term timing jitter, and a read strobe that it generates itself at a smoothed rate. Both strobes are single-cycle enables inside one system clock domain. A numerically controlled oscillator produces the read strobe. Its increment is steered by the fill-level error, so over time the read rate settles on the average write rate.

Three bandwidth settings are possible. The line mode (T1 or E1) and an E1 bandwidth select choose one of three narrow loop gains. Whenever the fill level comes within two bits of empty or full, the loop changes to a large fixed gain so that the output follows the input closely. The slowest E1 setting also forces the larger of the two store depths. Bits leave the store in the order they arrived. Nominal latency is half the active depth. If a slip cannot be avoided, a sticky flag is raised and the pointers are moved back to half depth.

Top module: `ja_elastic_store`

## Requirements
- R1: `depth_64`=1 selects an active depth of 64 bits and `depth_64`=0 selects 32 bits, unless R2 applies.
- R2: When `line_e1`=1 and `e1_low_bw`=1, the active depth is 64 bits whatever `depth_64` says.
- R3: When `line_e1`=0, `e1_low_bw` has no effect. The depth follows `depth_64` alone, and changing `e1_low_bw` neither flushes the store nor changes the fill level.
- R4: The fill level is the number of accepted writes minus the number of reads. `track` is 1 in exactly those cycles in which the fill level is at most 2, or at least the active depth minus 2.
- R5: After reset, and in the cycle after any change of the active depth, the store is empty. The write in the change cycle is dropped. `rd_stb` stays 0 until the cycle after the fill level has reached half the active depth.
- R6: In every cycle with `rd_stb`=1 and a non-empty store, `dout` carries the oldest unread bit, so bits come out in write order.
- R7: A write with no read while the store is full is dropped. It sets `slip_err`, the fill level becomes half the depth, and the store then holds the last half-depth bits that were written.
- R8: A read while the store is empty sets `slip_err`, and the fill level becomes half the depth. The following reads replay the last half-depth bits that were written.
- R9: `slip_err` is 0 after reset and stays 1 once set, until the next reset.
- R10: With writes at the nominal rate of one per four cycles and plus or minus one cycle of jitter, no slip occurs once priming is done, and `track` stays 0 in all three bandwidth settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 1 | Data bit written when `wr_stb` is 1 |
| wr_stb | input | 1 | Write strobe (jittery input rate) |
| line_e1 | input | 1 | Line mode: 0 = T1, 1 = E1 |
| e1_low_bw | input | 1 | E1 only: 1 = lowest bandwidth, 0 = higher bandwidth |
| depth_64 | input | 1 | Depth select: 1 = 64 bits, 0 = 32 bits |
| dout | output | 1 | Data bit, valid when `rd_stb` is 1 |
| rd_stb | output | 1 | Smoothed read strobe |
| track | output | 1 | Wide-bandwidth fast-tracking state (fill near empty or full) |
| slip_err | output | 1 | Sticky overflow or underflow flag |

## Verification
Underflow is the hardest state to reach. The loop fights it: as the fill level drops, the read rate falls, and near empty the wide gain pushes the increment down to its floor. The stimulus primes the store at the nominal rate and then stops writing completely for several thousand cycles, so the clamped minimum read rate finally drains the last bit. The bench follows the fill level, the priming state, the depth change and both recentring events with its own counter, built from the observed strobes. This lets it compare `track`, `dout` and `slip_err` in every cycle, including the replayed half-depth of data after each slip.

// File: rtl/ja_pkg.sv
// Package: shared types and helpers for the jitter attenuator elastic store.
// Assumes: the large depth is exactly twice the small depth.
package ja_pkg;

    // Loop bandwidth class selected from the line mode pins.
    typedef enum logic [1:0] {
        LOOP_MID  = 2'd0,   // T1: single narrow setting
        LOOP_FAST = 2'd1,   // E1: wider of the two narrow settings
        LOOP_SLOW = 2'd2    // E1: narrowest setting, forces large depth
    } loop_bw_e;

    // Large depth is required by the depth pin or by the slowest E1 loop.
    function automatic logic need_big_depth(input logic e1, input logic low_bw,
                                            input logic want64);
        return want64 | (e1 & low_bw);
    endfunction

endpackage

// File: rtl/ja_mode_ctl.sv
// Module: decodes the line mode pins into the depth choice and loop class.
// Assumes: pins are static or change rarely; any change of depth is handled
// downstream as a flush.
module ja_mode_ctl
    import ja_pkg::*;
(
    input  logic     line_e1,
    input  logic     e1_low_bw,
    input  logic     depth_64,
    output logic     big_depth,
    output loop_bw_e bw_mode
);

    // Depth: the slowest E1 loop overrides the depth pin.
    always_comb begin
        big_depth = need_big_depth(line_e1, e1_low_bw, depth_64);
    end

    // Loop class: T1 ignores the E1 bandwidth pin.
    always_comb begin
        if (!line_e1)
            bw_mode = LOOP_MID;
        else if (e1_low_bw)
            bw_mode = LOOP_SLOW;
        else
            bw_mode = LOOP_FAST;
    end

endmodule

// File: rtl/ja_bit_store.sv
// Module: one-bit circular store with fill counter, priming, slip recentring
// and the near-empty/near-full tracking window.
// Assumes: tick comes from the rate oscillator; the store's active depth is
// registered, so any change in the requested depth flushes for one cycle.
module ja_bit_store #(
    parameter int MAX_AW = 6,               // log2 of the large depth
    parameter int GUARD  = 2,               // tracking window in bits
    localparam int DEPTH_MAX = 1 << MAX_AW,
    localparam int FW        = MAX_AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          big_depth,
    input  logic          din,
    input  logic          wr_stb,
    input  logic          tick,
    output logic          dout,
    output logic          rd_stb,
    output logic [FW-1:0] fill,
    output logic [FW-1:0] half,
    output logic [FW-1:0] depth,
    output logic          primed,
    output logic          track,
    output logic          slip,
    output logic          flush,
    output logic          slip_err
);

    localparam logic [FW-1:0] DEPTH_BIG   = FW'(DEPTH_MAX);
    localparam logic [FW-1:0] DEPTH_SMALL = FW'(DEPTH_MAX / 2);
    localparam logic [FW-1:0] GUARD_W     = FW'(GUARD);

    logic [DEPTH_MAX-1:0] mem;
    logic [MAX_AW-1:0]    wptr, rptr, amask;
    logic                 big_q;
    logic                 full, empty, ovf, unf, rd_ok, wr_ok;

    // Active geometry from the registered depth choice.
    always_comb begin
        depth = big_q ? DEPTH_BIG : DEPTH_SMALL;
        half  = depth >> 1;
        amask = big_q ? {MAX_AW{1'b1}} : {1'b0, {(MAX_AW-1){1'b1}}};
    end

    // Event decode: flush, read, overflow and underflow.
    always_comb begin
        flush  = big_depth != big_q;
        rd_stb = primed & tick & ~flush;
        full   = fill == depth;
        empty  = fill == '0;
        ovf    = wr_stb & ~rd_stb & full & ~flush;
        unf    = rd_stb & empty;
        slip   = ovf | unf;
        wr_ok  = wr_stb & ~flush & ~slip;
        rd_ok  = rd_stb & ~slip;
    end

    // Tracking window: close to empty or close to full.
    always_comb begin
        track = (fill <= GUARD_W) | (fill >= depth - GUARD_W);
    end

    // Output bit at the read pointer.
    always_comb begin
        dout = mem[rptr];
    end

    // Bit storage: accepted writes only.
    always_ff @(posedge clk) begin
        if (rst_n && wr_ok)
            mem[wptr] <= din;
    end

    // Pointer, fill, priming and sticky error state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr     <= '0;
            rptr     <= '0;
            fill     <= '0;
            big_q    <= 1'b0;
            primed   <= 1'b0;
            slip_err <= 1'b0;
        end else if (flush) begin
            wptr   <= '0;
            rptr   <= '0;
            fill   <= '0;
            primed <= 1'b0;
            big_q  <= big_depth;
        end else begin
            primed <= primed | (fill >= half);
            if (slip) begin
                slip_err <= 1'b1;
                fill     <= half;
                rptr     <= (wptr - half[MAX_AW-1:0]) & amask;
            end else begin
                if (wr_ok)
                    wptr <= (wptr + 1'b1) & amask;
                if (rd_ok)
                    rptr <= (rptr + 1'b1) & amask;
                case ({wr_ok, rd_ok})
                    2'b10:   fill <= fill + 1'b1;
                    2'b01:   fill <= fill - 1'b1;
                    default: fill <= fill;
                endcase
            end
        end
    end

endmodule

// File: rtl/ja_rate_nco.sv
// Module: read-rate oscillator. A phase accumulator whose carry is the read
// tick; its increment is nominal plus a fill-error correction whose gain is
// set by the loop class, or a large fixed gain while tracking.
// Assumes: run is low until the store is primed; the integrator is held
// while tracking so the narrow loop resumes from its pre-excursion value.
module ja_rate_nco
    import ja_pkg::*;
#(
    parameter int ACC_W   = 12,     // accumulator width
    parameter int NOM_INC = 1024,   // nominal increment (rate NOM_INC/2^ACC_W)
    parameter int MIN_INC = 16,     // increment floor
    parameter int PROP_SH = 2,      // proportional gain shift, narrow loop
    parameter int WIDE_SH = 6,      // proportional gain shift, tracking
    parameter int INT_W   = 24,     // integrator width
    parameter int SH_FAST = 10,     // integral shift, wider E1 loop
    parameter int SH_MID  = 12,     // integral shift, T1 loop
    parameter int SH_SLOW = 14,     // integral shift, narrowest E1 loop
    parameter int FW      = 7,      // fill width
    localparam int SUM_W  = INT_W + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          wide,
    input  loop_bw_e      bw_mode,
    input  logic [FW-1:0] fill,
    input  logic [FW-1:0] half,
    output logic          tick
);

    localparam logic signed [SUM_W-1:0] NOM_S = SUM_W'(NOM_INC);
    localparam logic signed [SUM_W-1:0] MIN_S = SUM_W'(MIN_INC);
    localparam logic signed [SUM_W-1:0] MAX_S = SUM_W'((1 << ACC_W) - 1);

    logic        [ACC_W-1:0] acc;
    logic        [ACC_W:0]   acc_sum;
    logic signed [INT_W-1:0] integ;
    logic signed [FW:0]      err;
    logic signed [SUM_W-1:0] err_x, int_x, raw;
    logic        [ACC_W-1:0] inc;
    logic        [4:0]       sh;

    // Integral shift from the loop class.
    always_comb begin
        case (bw_mode)
            LOOP_FAST: sh = 5'(SH_FAST);
            LOOP_SLOW: sh = 5'(SH_SLOW);
            default:   sh = 5'(SH_MID);
        endcase
    end

    // Fill error and the clamped increment.
    always_comb begin
        err   = $signed({1'b0, fill}) - $signed({1'b0, half});
        err_x = {{(SUM_W-FW-1){err[FW]}}, err};
        int_x = {{(SUM_W-INT_W){integ[INT_W-1]}}, integ};
        if (wide)
            raw = NOM_S + (err_x <<< WIDE_SH);
        else
            raw = NOM_S + (err_x <<< PROP_SH) + (int_x >>> sh);
        if (raw < MIN_S)
            inc = MIN_S[ACC_W-1:0];
        else if (raw > MAX_S)
            inc = MAX_S[ACC_W-1:0];
        else
            inc = raw[ACC_W-1:0];
        acc_sum = {1'b0, acc} + {1'b0, inc};
        tick    = acc_sum[ACC_W];
    end

    // Phase and integrator state; both cleared while not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            acc   <= '0;
            integ <= '0;
        end else begin
            acc <= acc_sum[ACC_W-1:0];
            if (!wide)
                integ <= integ + err_x[INT_W-1:0];
        end
    end

endmodule

// File: rtl/ja_elastic_store.sv
// Module: top of the jitter attenuator elastic store. Wires the mode decode,
// the bit store and the read-rate oscillator.
// Assumes: one clock domain; write and read rates are strobes on clk.
module ja_elastic_store #(
    parameter int MAX_AW  = 6,
    parameter int GUARD   = 2,
    parameter int ACC_W   = 12,
    parameter int NOM_INC = 1024,
    parameter int MIN_INC = 16,
    parameter int PROP_SH = 2,
    parameter int WIDE_SH = 6,
    parameter int INT_W   = 24,
    localparam int FW     = MAX_AW + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic wr_stb,
    input  logic line_e1,
    input  logic e1_low_bw,
    input  logic depth_64,
    output logic dout,
    output logic rd_stb,
    output logic track,
    output logic slip_err
);

    ja_pkg::loop_bw_e bw_mode;
    logic             big_depth, tick, primed, slip, flush;
    logic [FW-1:0]    fill, half, depth;

    ja_mode_ctl u_mode (
        .line_e1   (line_e1),
        .e1_low_bw (e1_low_bw),
        .depth_64  (depth_64),
        .big_depth (big_depth),
        .bw_mode   (bw_mode)
    );

    ja_bit_store #(
        .MAX_AW (MAX_AW),
        .GUARD  (GUARD)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .big_depth (big_depth),
        .din       (din),
        .wr_stb    (wr_stb),
        .tick      (tick),
        .dout      (dout),
        .rd_stb    (rd_stb),
        .fill      (fill),
        .half      (half),
        .depth     (depth),
        .primed    (primed),
        .track     (track),
        .slip      (slip),
        .flush     (flush),
        .slip_err  (slip_err)
    );

    ja_rate_nco #(
        .ACC_W   (ACC_W),
        .NOM_INC (NOM_INC),
        .MIN_INC (MIN_INC),
        .PROP_SH (PROP_SH),
        .WIDE_SH (WIDE_SH),
        .INT_W   (INT_W),
        .FW      (FW)
    ) u_nco (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (primed),
        .wide    (track),
        .bw_mode (bw_mode),
        .fill    (fill),
        .half    (half),
        .tick    (tick)
    );

endmodule

// File: rtl/ja_elastic_store_chk.sv
// Checker: temporal properties of the elastic store, bound to the top.
// Assumes: signals are sampled on clk; reset is synchronous active-low.
module ja_elastic_store_chk #(
    parameter int MAX_AW = 6,
    localparam int FW    = MAX_AW + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          line_e1,
    input logic          e1_low_bw,
    input logic          rd_stb,
    input logic          slip_err,
    input logic          primed,
    input logic          slip,
    input logic          flush,
    input logic [FW-1:0] fill,
    input logic [FW-1:0] half,
    input logic [FW-1:0] depth
);

    localparam logic [FW-1:0] BIG = FW'(1 << MAX_AW);

    // R4: fill never exceeds the active depth.
    p_fill_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= depth);

    // R4: outside slips and flushes the fill moves by at most one.
    p_fill_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!slip && !flush) |->
            (fill == $past(fill)) || (fill == $past(fill) + 1'b1) ||
            (fill + 1'b1 == $past(fill)));

    // R7 / R8: a slip recentres to half depth and raises the error.
    p_recentre_r7: assert property (@(posedge clk) disable iff (!rst_n)
        slip |=> (fill == $past(half)) && slip_err);

    // R9: the error flag is sticky.
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        slip_err |=> slip_err);

    // R5: a depth change empties the store and restarts priming.
    p_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (fill == '0) && !primed && !rd_stb);

    // R2: the slowest E1 loop runs on the large depth.
    p_e1low_big_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_e1 && e1_low_bw && !flush) |-> depth == BIG);

endmodule

bind ja_elastic_store ja_elastic_store_chk #(.MAX_AW(MAX_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_e1   (line_e1),
    .e1_low_bw (e1_low_bw),
    .rd_stb    (rd_stb),
    .slip_err  (slip_err),
    .primed    (primed),
    .slip      (slip),
    .flush     (flush),
    .fill      (fill),
    .half      (half),
    .depth     (depth)
);

// File: tb/ja_elastic_store_bench.sv
// Bench: cycle-by-cycle reference model of the fill level, priming, depth
// and slips built from observed strobes, plus directed phases per mode.
module ja_elastic_store_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic din = 1'b0, wr_stb = 1'b0;
    logic line_e1 = 1'b0, e1_low_bw = 1'b0, depth_64 = 1'b0;
    logic dout, rd_stb, track, slip_err;

    always #10 clk = ~clk;

    ja_elastic_store u_ja_elastic_store (
        .clk(clk), .rst_n(rst_n), .din(din), .wr_stb(wr_stb),
        .line_e1(line_e1), .e1_low_bw(e1_low_bw), .depth_64(depth_64),
        .dout(dout), .rd_stb(rd_stb), .track(track), .slip_err(slip_err)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Reference model state (state present in the current cycle).
    int m_fill = 0;
    bit m_primed = 0, m_err = 0, m_big = 0;
    bit hist[$];
    bit rq[$];
    bit r10_watch = 0;
    int r10_hits = 0;

    // Per-cycle compare and model advance at the falling edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            m_fill = 0; m_primed = 0; m_err = 0; m_big = 0;
            hist.delete(); rq.delete();
        end else begin
            bit big_req;
            int dq, hq, old_fill;
            big_req  = depth_64 | (line_e1 & e1_low_bw);
            dq       = m_big ? 64 : 32;
            hq       = dq / 2;
            old_fill = m_fill;
            chk(track === ((m_fill <= 2) || (m_fill >= dq - 2)), "R4 track window",
                int'(track), int'((m_fill <= 2) || (m_fill >= dq - 2)));
            if (!m_primed)
                chk(rd_stb === 1'b0, "R5 read before primed", int'(rd_stb), 0);
            chk(slip_err === m_err, "R9 slip_err", int'(slip_err), int'(m_err));
            if (r10_watch && track) r10_hits++;
            if (big_req != m_big) begin
                m_fill = 0; m_primed = 0; m_big = big_req;
                hist.delete(); rq.delete();
            end else begin
                bit ovf, unf;
                ovf = wr_stb && !rd_stb && (m_fill == dq);
                unf = rd_stb && (m_fill == 0);
                m_primed = m_primed | (old_fill >= hq);
                if (ovf || unf) begin
                    m_err  = 1;
                    m_fill = hq;
                    rq.delete();
                    for (int k = hist.size() - hq; k < hist.size(); k++)
                        rq.push_back(hist[k]);
                end else begin
                    if (rd_stb && rq.size() > 0) begin
                        bit e;
                        e = rq.pop_front();
                        chk(dout === e, "R6 read order", int'(dout), int'(e));
                    end
                    if (wr_stb) begin
                        hist.push_back(din);
                        rq.push_back(din);
                        if (hist.size() > 64) void'(hist.pop_front());
                    end
                    m_fill = m_fill + int'(wr_stb) - int'(rd_stb);
                end
            end
        end
    end

    // One cycle of stimulus, applied after the rising edge.
    task automatic cyc(input bit w);
        @(posedge clk);
        #2;
        wr_stb = w;
        din    = lfsr[0];
        lfsr   = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    task automatic do_reset(input bit e1, input bit lo, input bit d64);
        @(posedge clk);
        #2;
        rst_n = 0; wr_stb = 0;
        line_e1 = e1; e1_low_bw = lo; depth_64 = d64;
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1;
        @(negedge clk);
        #1;
        chk(rd_stb === 1'b0, "R5 reset rd_stb", int'(rd_stb), 0);
        chk(track === 1'b1, "R4 reset track", int'(track), 1);
        chk(slip_err === 1'b0, "R9 reset slip_err", int'(slip_err), 0);
    endtask

    // Nominal-rate writes with a 3,5,4,4 gap pattern.
    task automatic jitter_writes(input int n);
        for (int i = 0; i < n; i++) begin
            int gap;
            gap = (i % 4 == 0) ? 3 : ((i % 4 == 1) ? 5 : 4);
            cyc(1);
            repeat (gap - 1) cyc(0);
        end
    endtask

    // Overflow then underflow for one configuration.
    task automatic slip_phase(input bit e1, input bit lo, input bit d64, input string tag);
        do_reset(e1, lo, d64);
        for (int i = 0; i < 600 && !slip_err; i++) cyc(1);
        cyc(0);
        chk(slip_err === 1'b1, {"R7 overflow ", tag}, int'(slip_err), 1);
        repeat (200) cyc(0);
        do_reset(e1, lo, d64);
        jitter_writes(100);
        for (int i = 0; i < 12000 && !slip_err; i++) cyc(0);
        repeat (300) cyc(0);
        chk(slip_err === 1'b1, {"R8 underflow ", tag}, int'(slip_err), 1);
    endtask

    task automatic steady_phase(input bit e1, input bit lo, input string tag);
        do_reset(e1, lo, 1'b0);
        jitter_writes(200);
        r10_hits  = 0;
        r10_watch = 1;
        jitter_writes(1300);
        r10_watch = 0;
        chk(r10_hits == 0, {"R10 track stays low ", tag}, r10_hits, 0);
        chk(slip_err === 1'b0, {"R10 no slip ", tag}, int'(slip_err), 0);
    endtask

    initial begin
        slip_phase(1'b0, 1'b0, 1'b0, "R1 depth 32");
        slip_phase(1'b0, 1'b0, 1'b1, "R1 depth 64");
        slip_phase(1'b0, 1'b1, 1'b0, "R3 T1 ignores low bw");
        slip_phase(1'b1, 1'b1, 1'b0, "R2 E1 low forces 64");
        slip_phase(1'b1, 1'b0, 1'b0, "R1 E1 depth 32");
        steady_phase(1'b0, 1'b0, "T1");
        steady_phase(1'b1, 1'b0, "E1 wide");
        steady_phase(1'b1, 1'b1, "E1 narrow");
        // R3: in T1 the E1 bandwidth pin must not flush the primed store.
        do_reset(1'b0, 1'b0, 1'b0);
        jitter_writes(150);
        @(posedge clk); #2; e1_low_bw = 1'b1; wr_stb = 1'b0;
        @(posedge clk); #2;
        @(negedge clk); #1;
        chk(track === 1'b0, "R3 no flush on e1_low_bw in T1", int'(track), 0);
        jitter_writes(100);
        // R5: a depth change empties the store and stops reading.
        @(posedge clk); #2; depth_64 = 1'b1; wr_stb = 1'b0;
        @(posedge clk); #2;
        @(negedge clk); #1;
        chk(track === 1'b1, "R5 flush empties store", int'(track), 1);
        chk(rd_stb === 1'b0, "R5 no read after flush", int'(rd_stb), 0);
        jitter_writes(300);
        chk(slip_err === 1'b0, "R5 no slip after refill", int'(slip_err), 0);
        report();
    end

    initial begin
        repeat (195000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        report();
    end

endmodule